// File: doc/BRIEF.md
# Nibble-Masked Vectored Interrupt Controller

This block arbitrates the interrupt and exception requests of one processor core and turns the winning request into the word address of its slot in a table of 32-bit vectors. Every interrupt line has a 4-bit enable field. The fields are packed eight to a 32-bit register, and a line can take part in arbitration only when all four bits of its field are set. A synchronous exception cause overrides all interrupt lines.

The table starts at a base address that is forced to a 512-byte boundary. Exception causes use the first block of slots. Interrupt line n uses slot `NUM_EXC + n`. The controller offers its choice to the core with a request. When the core acknowledges, the controller records the slot number in a status register and freezes the vector until the core signals end of service. While no request is in service, the status register reads 0xFF.

Software reaches the registers through a single-cycle register port. Word indices 0 up to `NUM_REGS-1` hold the mask registers, index 8 holds the vector base and index 9 holds the status.

Top module: `nibvec_intc`

## Requirements
- R1: After reset, every mask register and the vector base read 0, the status register (index 9) reads 0x000000FF, and `irq_req` stays low whatever levels appear on `line_i`.
- R2: The field for interrupt line n lives in mask register n/8, at bits [4*(n%8)+3 : 4*(n%8)]. For example, line 57 is controlled by bits 7:4 of register 7. Mask registers read back exactly what was written.
- R3: A line takes part in arbitration only when its field equals 0xF. Any other field value, such as 0xE or 0x7, keeps the line from raising `irq_req`.
- R4: A write to the vector base (index 8) stores the written value with bits 8:0 cleared, and the register reads back that way.
- R5: While `exc_valid` is high, the winning slot is `exc_cause` (0 to 31), whatever interrupt lines are active. For example, cause 2 selects slot 2.
- R6: With no exception pending, the lowest-numbered line that is both high and fully enabled wins, and it selects slot 32+n.
- R7: While `irq_req` is high, `irq_vec` equals base + 4 × slot.
- R8: An `irq_ack` sampled with `irq_req` high has three effects from the next cycle on: status bits 7:0 hold the slot number and the upper bits hold 0, `irq_req` is low, and `irq_vec` holds its acknowledged value even if the inputs change.
- R9: While a request is in service, no new request is raised. One cycle after `irq_eos`, the status reads 0xFF again, and `irq_req` rises at once if a candidate is pending.
- R10: Writes to the status index have no effect on the status value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| line_i | input | NUM_LINES | Level-sensitive interrupt lines |
| exc_valid | input | 1 | Exception pending |
| exc_cause | input | $clog2(NUM_EXC) | Exception cause number |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | DATA_W | Byte address of the selected vector slot |
| irq_ack | input | 1 | Core accepts the request |
| irq_eos | input | 1 | Core finished servicing |

## Verification
The bench builds the block with its default parameters: 64 lines, 32 exception causes, 4-bit fields and 32-bit data. This gives eight fully packed mask registers. With these values the bench can reach both the lowest and the highest nibble of the last register, including line 57, and the top of the 96-slot table. It can also exercise slot numbers that cross from the exception block into the interrupt block, which show whether the offset of 32 is applied at the right place.

// File: rtl/nvi_pkg.sv
package nvi_pkg;
   localparam int          REG_ADDR_W  = 4;
   localparam logic [3:0]  RA_BASE     = 4'd8;
   localparam logic [3:0]  RA_STATUS   = 4'd9;
   localparam logic [7:0]  STATUS_IDLE = 8'hFF;
   localparam int          SLOT_W      = 8;
   localparam int          ALIGN_BITS  = 9;

   typedef enum logic {
      SVC_IDLE = 1'b0,
      SVC_BUSY = 1'b1
   } svc_state_e;
endpackage

// File: rtl/nvi_mask_bank.sv
module nvi_mask_bank #(
   parameter int NUM_LINES = 64,
   parameter int FIELD_W   = 4,
   parameter int DATA_W    = 32,
   localparam int PER_REG  = DATA_W / FIELD_W,
   localparam int NUM_REGS = (NUM_LINES + PER_REG - 1) / PER_REG,
   localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] regs_o [NUM_REGS],
   output logic [NUM_LINES-1:0] line_en_o
);
   if (DATA_W % FIELD_W != 0) begin : g_bad_field
      $error("DATA_W must be a multiple of FIELD_W");
   end

   logic [DATA_W-1:0] mask_q [NUM_REGS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[r] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(r)))
            mask_q[r] <= wr_data;
      end
      assign regs_o[r] = mask_q[r];
   end

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      assign line_en_o[n] = &mask_q[n / PER_REG][(n % PER_REG) * FIELD_W +: FIELD_W];
   end
endmodule

// File: rtl/nvi_pick.sv
module nvi_pick #(
   parameter int N      = 64,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] idx_o
);
   if (N < 1) begin : g_bad_n
      $error("N must be at least 1");
   end

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign valid_o = |req_i;
endmodule

// File: rtl/nvi_service.sv
module nvi_service
   import nvi_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid_i,
   input  logic [SLOT_W-1:0] cand_slot_i,
   input  logic [DATA_W-1:0] cand_vec_i,
   input  logic              ack_i,
   input  logic              eos_i,
   output logic              req_o,
   output logic [DATA_W-1:0] vec_o,
   output logic [SLOT_W-1:0] status_o
);
   svc_state_e        state_q;
   logic [SLOT_W-1:0] held_slot_q;
   logic [DATA_W-1:0] held_vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SVC_IDLE;
         held_slot_q <= '0;
         held_vec_q  <= '0;
      end else begin
         case (state_q)
            SVC_IDLE: if (cand_valid_i && ack_i) begin
               state_q     <= SVC_BUSY;
               held_slot_q <= cand_slot_i;
               held_vec_q  <= cand_vec_i;
            end
            SVC_BUSY: if (eos_i) state_q <= SVC_IDLE;
            default:  state_q <= SVC_IDLE;
         endcase
      end
   end

   assign req_o    = (state_q == SVC_IDLE) && cand_valid_i;
   assign vec_o    = (state_q == SVC_BUSY) ? held_vec_q : cand_vec_i;
   assign status_o = (state_q == SVC_BUSY) ? held_slot_q : STATUS_IDLE;

   // R8: acceptance latches the slot and drops the request
   p_ack_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i) |=> (!req_o && status_o == $past(cand_slot_i)));

   // R8: vector frozen while in service
   p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SVC_BUSY && !eos_i) |=> $stable(vec_o));

   // R9: end of service returns status to idle code
   p_eos_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SVC_BUSY && eos_i) |=> (status_o == STATUS_IDLE));
endmodule

// File: rtl/nibvec_intc.sv
module nibvec_intc
   import nvi_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int NUM_EXC   = 32,
   parameter int FIELD_W   = 4,
   parameter int DATA_W    = 32,
   localparam int EXC_W    = $clog2(NUM_EXC),
   localparam int PER_REG  = DATA_W / FIELD_W,
   localparam int NUM_REGS = (NUM_LINES + PER_REG - 1) / PER_REG,
   localparam int MIDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int LIDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic [NUM_LINES-1:0]  line_i,
   input  logic                  exc_valid,
   input  logic [EXC_W-1:0]      exc_cause,
   output logic                  irq_req,
   output logic [DATA_W-1:0]     irq_vec,
   input  logic                  irq_ack,
   input  logic                  irq_eos
);
   if (NUM_EXC + NUM_LINES > 255) begin : g_bad_slots
      $error("slot numbers must fit below the idle status code");
   end
   if (NUM_REGS > 8) begin : g_bad_map
      $error("mask registers must fit below the base index");
   end
   if (NUM_EXC < 2 || (1 << EXC_W) != NUM_EXC) begin : g_bad_exc
      $error("NUM_EXC must be a power of two");
   end
   if (DATA_W < SLOT_W + 2 + ALIGN_BITS) begin : g_bad_width
      $error("DATA_W too small for the vector address");
   end

   localparam logic [DATA_W-1:0] ALIGN_MASK = ~DATA_W'((1 << ALIGN_BITS) - 1);

   logic [DATA_W-1:0]    mask_regs [NUM_REGS];
   logic [NUM_LINES-1:0] line_en;
   logic [NUM_LINES-1:0] line_act;
   logic                 ln_valid;
   logic [LIDX_W-1:0]    ln_idx;
   logic [DATA_W-1:0]    base_q;
   logic                 cand_valid;
   logic [SLOT_W-1:0]    cand_slot;
   logic [DATA_W-1:0]    cand_vec;
   logic [SLOT_W-1:0]    status_slot;
   logic                 mask_wr;

   assign mask_wr = reg_wr && (reg_addr < REG_ADDR_W'(NUM_REGS));

   nvi_mask_bank #(
      .NUM_LINES (NUM_LINES),
      .FIELD_W   (FIELD_W),
      .DATA_W    (DATA_W)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (mask_wr),
      .wr_idx    (reg_addr[MIDX_W-1:0]),
      .wr_data   (reg_wdata),
      .regs_o    (mask_regs),
      .line_en_o (line_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         base_q <= '0;
      else if (reg_wr && reg_addr == RA_BASE)
         base_q <= reg_wdata & ALIGN_MASK;
   end

   assign line_act = line_i & line_en;

   nvi_pick #(.N(NUM_LINES)) u_pick (
      .req_i   (line_act),
      .valid_o (ln_valid),
      .idx_o   (ln_idx)
   );

   assign cand_valid = exc_valid || ln_valid;
   assign cand_slot  = exc_valid ? SLOT_W'(exc_cause)
                                 : SLOT_W'(NUM_EXC) + SLOT_W'(ln_idx);
   assign cand_vec   = base_q + {{(DATA_W-SLOT_W-2){1'b0}}, cand_slot, 2'b00};

   nvi_service #(.DATA_W(DATA_W)) u_svc (
      .clk          (clk),
      .rst_n        (rst_n),
      .cand_valid_i (cand_valid),
      .cand_slot_i  (cand_slot),
      .cand_vec_i   (cand_vec),
      .ack_i        (irq_ack),
      .eos_i        (irq_eos),
      .req_o        (irq_req),
      .vec_o        (irq_vec),
      .status_o     (status_slot)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr < REG_ADDR_W'(NUM_REGS))
         reg_rdata = mask_regs[reg_addr[MIDX_W-1:0]];
      else if (reg_addr == RA_BASE)
         reg_rdata = base_q;
      else if (reg_addr == RA_STATUS)
         reg_rdata = {{(DATA_W-SLOT_W){1'b0}}, status_slot};
   end

   // R5: an accepted request during an exception records the cause
   p_exc_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && exc_valid) |=> (status_slot == SLOT_W'($past(exc_cause))));

   // R6: an accepted interrupt lands in the interrupt block of slots
   p_line_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_ack && !exc_valid) |=> (status_slot >= SLOT_W'(NUM_EXC)));

   // R7: offered vector is word aligned and inside the table
   p_vec_in_table_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_vec[1:0] == 2'b00 &&
                   (irq_vec - base_q) < DATA_W'(4 * (NUM_EXC + NUM_LINES))));
endmodule

// File: tb/nibvec_intc_bench.sv
`timescale 1ns/1ps
module nibvec_intc_bench;
   localparam int NL = 64;
   localparam int NE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NL-1:0] line_i = '0;
   logic        exc_valid = 1'b0;
   logic [4:0]  exc_cause = '0;
   logic        irq_req;
   logic [31:0] irq_vec;
   logic        irq_ack = 1'b0;
   logic        irq_eos = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   nibvec_intc u_nibvec_intc (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .line_i, .exc_valid, .exc_cause, .irq_req, .irq_vec, .irq_ack, .irq_eos
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_wr = 0; line_i = '0; exc_valid = 0; irq_ack = 0; irq_eos = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic ack_pulse();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      #1;
   endtask

   task automatic eos_pulse();
      @(negedge clk);
      irq_eos = 1'b1;
      @(negedge clk);
      irq_eos = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      rd(4'd0, d); chk("R1 mask0", d, 32'h0);
      rd(4'd7, d); chk("R1 mask7", d, 32'h0);
      rd(4'd8, d); chk("R1 base", d, 32'h0);
      rd(4'd9, d); chk("R1 status", d, 32'hFF);
      line_i = '1;
      settle(); chk("R1 no req while masked", 32'(irq_req), 32'h0);
      line_i = '0;
   endtask

   task automatic t_map();
      logic [31:0] d;
      do_reset();
      wr(4'd8, 32'h0000_4000);
      wr(4'd7, 32'h0000_00F0);
      rd(4'd7, d); chk("R2 readback", d, 32'h0000_00F0);
      line_i = '0; line_i[56] = 1'b1;
      settle(); chk("R2 line56 masked", 32'(irq_req), 32'h0);
      line_i = '0; line_i[57] = 1'b1;
      settle(); chk("R2 line57 req", 32'(irq_req), 32'h1);
      chk("R7 line57 vec", irq_vec, 32'h4000 + 4 * (NE + 57));
      wr(4'd7, 32'hF000_0000);
      line_i = '0; line_i[63] = 1'b1;
      settle(); chk("R2 line63 req", 32'(irq_req), 32'h1);
      chk("R7 line63 vec", irq_vec, 32'h4000 + 4 * (NE + 63));
      line_i = '0;
   endtask

   task automatic t_nibble();
      do_reset();
      line_i = '0; line_i[57] = 1'b1;
      wr(4'd7, 32'h0000_00E0);
      settle(); chk("R3 nibble E masks", 32'(irq_req), 32'h0);
      wr(4'd7, 32'h0000_0070);
      settle(); chk("R3 nibble 7 masks", 32'(irq_req), 32'h0);
      wr(4'd7, 32'hFFFF_FF0F);
      settle(); chk("R3 other nibbles full", 32'(irq_req), 32'h0);
      line_i = '0;
   endtask

   task automatic t_base();
      logic [31:0] d;
      do_reset();
      wr(4'd8, 32'hFFFF_FFFF);
      rd(4'd8, d); chk("R4 low bits cleared", d, 32'hFFFF_FE00);
      wr(4'd8, 32'h0001_0200);
      rd(4'd8, d); chk("R4 aligned value", d, 32'h0001_0200);
   endtask

   task automatic t_prio();
      do_reset();
      wr(4'd8, 32'h0002_0000);
      wr(4'd0, 32'hFFFF_FFFF);
      wr(4'd1, 32'hFFFF_FFFF);
      line_i = '0; line_i[12] = 1; line_i[5] = 1; line_i[3] = 1;
      settle(); chk("R6 lowest wins vec", irq_vec, 32'h2_0000 + 4 * (NE + 3));
      wr(4'd0, 32'hFFFF_0FFF);
      settle(); chk("R6 skip masked line3", irq_vec, 32'h2_0000 + 4 * (NE + 5));
      line_i[0] = 1'b1;
      settle(); chk("R6 line0 slot32", irq_vec, 32'h2_0000 + 4 * NE);
      exc_valid = 1'b1; exc_cause = 5'd2;
      settle(); chk("R5 exception wins", irq_vec, 32'h2_0000 + 8);
      exc_cause = 5'd31;
      settle(); chk("R5 cause31", irq_vec, 32'h2_0000 + 4 * 31);
      exc_valid = 1'b0; line_i = '0;
      settle(); chk("R6 idle no req", 32'(irq_req), 32'h0);
   endtask

   task automatic t_service();
      logic [31:0] d;
      do_reset();
      wr(4'd8, 32'h0000_8000);
      wr(4'd6, 32'hFFFF_FFFF);
      wr(4'd7, 32'hFFFF_FFFF);
      line_i = '0; line_i[50] = 1'b1;
      settle();
      ack_pulse();
      chk("R8 req drops", 32'(irq_req), 32'h0);
      rd(4'd9, d); chk("R8 status slot", d, NE + 50);
      line_i[49] = 1'b1; exc_valid = 1'b1; exc_cause = 5'd4;
      settle(); chk("R8 vec held", irq_vec, 32'h8000 + 4 * (NE + 50));
      chk("R9 no req in service", 32'(irq_req), 32'h0);
      wr(4'd9, 32'h0000_0011);
      rd(4'd9, d); chk("R10 status write ignored", d, NE + 50);
      eos_pulse();
      rd(4'd9, d); chk("R9 status idle after eos", d, 32'hFF);
      chk("R9 new req after eos", 32'(irq_req), 32'h1);
      chk("R5 pending exc vec", irq_vec, 32'h8000 + 16);
      ack_pulse();
      rd(4'd9, d); chk("R5 status exc", d, 32'd4);
      exc_valid = 1'b0;
      eos_pulse();
      chk("R9 line49 next", irq_vec, 32'h8000 + 4 * (NE + 49));
      line_i = '0;
      wr(4'd9, 32'h0000_0005);
      rd(4'd9, d); chk("R10 idle status write ignored", d, 32'hFF);
   endtask

   initial begin
      t_reset();
      t_map();
      t_nibble();
      t_base();
      t_prio();
      t_service();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule